// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing skeleton of a single analog-to-digital conversion. A programmable even prescaler divides the system clock into a one-cycle ADC clock enable (`adc_clk_en`). The block does not create a separate derived clock. Each accepted command starts two phases, both counted in ADC clock ticks. The first is a sample window whose length comes from a two-bit code in the command. The second is a convert window whose length depends on whether the input is differential or single-ended. A one-cycle done pulse closes the convert window.

Commands arrive on a valid/ready handshake. The prescaler value is taken only while the sequencer is idle. The divider restarts when a command is accepted, so every conversion begins on a full divide period. A prescaler setting that would run the ADC clock faster than the parameter `MIN_DIV` allows is flagged, and no conversion can start while it is present.

Top module: `adc_conv_timer`

## Requirements
- R1: Synchronous reset returns the block to idle: sample and convert windows low, done low, and ready high when the prescaler is legal.
- R2: While idle, `adc_clk_en` pulses once every D system cycles, where D = 2*(N+1) and N is the prescaler input.
- R3: The sample window lasts S*D system cycles. S is 2 for code 00, 8 for 01, 64 for 10 and 128 for 11. The sample and convert windows are never high together.
- R4: The convert window follows the sample window directly and lasts 13*D cycles when `cmd_diff`=1 and 14*D cycles when `cmd_diff`=0.
- R5: The sample window rises in the cycle after acceptance. The first ADC tick of the conversion comes one full period D later, so the block is busy for exactly (S+C)*D cycles.
- R6: Each command produces exactly one `conv_done` pulse, in the last cycle of the convert window, coinciding with an ADC tick.
- R7: `cmd_ready` is low from the cycle after acceptance through the done cycle, and is high again in the cycle after done.
- R8: A change to the prescaler input while a conversion is running has no effect on that conversion's timing.
- R9: When 2*(N+1) < MIN_DIV, `config_error` is high, `cmd_ready` is low and a valid command starts nothing. At 2*(N+1) = MIN_DIV the flag is low.
- R10: A reset asserted during a conversion ends it: after the reset cycle both windows are low and ready is back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and prescaler legal |
| cmd_smp_code | input | 2 | Sample-time code (00:2, 01:8, 10:64, 11:128 ticks) |
| cmd_diff | input | 1 | 1 = differential (13 ticks), 0 = single-ended (14 ticks) |
| presc_in | input | PRESC_W | Prescaler N, divide factor 2*(N+1) |
| config_error | output | 1 | Divide factor below MIN_DIV |
| adc_clk_en | output | 1 | One-cycle ADC clock enable |
| sample_win | output | 1 | Sample phase active |
| conv_win | output | 1 | Convert phase active |
| conv_done | output | 1 | Last cycle of the convert phase |

## Verification
The bench builds the block with the default 5-bit prescaler and with MIN_DIV set to 4. With that setting, N=0 (divide by 2) is the single illegal value, and N=1 (divide by 4) is the fastest legal one. Both sides of the error boundary are therefore reached with short runs. The 5-bit prescaler still lets directed cases reach divide-by-64, including the longest sample code with a single-ended conversion.

// File: rtl/adc_timer_pkg.sv
package adc_timer_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_CONV   = 2'd2
   } phase_e;

   localparam int unsigned TICK_CNT_W = 8;

   // sample length in ADC ticks, selected by the command code
   function automatic logic [TICK_CNT_W-1:0] smp_ticks(input logic [1:0] code);
      case (code)
         2'b00:   return 8'd2;
         2'b01:   return 8'd8;
         2'b10:   return 8'd64;
         default: return 8'd128;
      endcase
   endfunction

   // convert length in ADC ticks, selected by input mode
   function automatic logic [TICK_CNT_W-1:0] conv_ticks(input logic diff);
      return diff ? 8'd13 : 8'd14;
   endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
   parameter int unsigned PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_en,
   input  logic               restart,
   input  logic [PRESC_W-1:0] presc_in,
   output logic               tick
);
   localparam int unsigned DIV_W = PRESC_W + 2;
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [PRESC_W-1:0] presc_q;
   logic [PRESC_W:0]   presc_p1;
   logic [DIV_W-1:0]   div_val;
   logic [DIV_W-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (rst)          presc_q <= '0;
      else if (load_en) presc_q <= presc_in;
   end

   assign presc_p1 = {1'b0, presc_q} + (PRESC_W+1)'(1);
   assign div_val  = {presc_p1, 1'b0};
   assign tick     = (cnt_q >= (div_val - ONE));

   always_ff @(posedge clk) begin
      if (rst || restart) cnt_q <= '0;
      else if (tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + ONE;
   end

endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
   import adc_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       fire,
   input  logic [1:0] smp_code,
   input  logic       diff,
   input  logic       tick,
   output phase_e     phase,
   output logic       done
);
   localparam logic [TICK_CNT_W-1:0] ONE = TICK_CNT_W'(1);

   phase_e                phase_q;
   logic [TICK_CNT_W-1:0] cnt_q;
   logic [TICK_CNT_W-1:0] smp_tgt_q;
   logic [TICK_CNT_W-1:0] conv_tgt_q;
   logic                  smp_last;
   logic                  conv_last;

   assign smp_last  = (cnt_q == smp_tgt_q - ONE);
   assign conv_last = (cnt_q == conv_tgt_q - ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         smp_tgt_q  <= '0;
         conv_tgt_q <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (fire) begin
               phase_q    <= PH_SAMPLE;
               cnt_q      <= '0;
               smp_tgt_q  <= smp_ticks(smp_code);
               conv_tgt_q <= conv_ticks(diff);
            end
            PH_SAMPLE: if (tick) begin
               if (smp_last) begin
                  phase_q <= PH_CONV;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            PH_CONV: if (tick) begin
               if (conv_last) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign done  = (phase_q == PH_CONV) && tick && conv_last;

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
   import adc_timer_pkg::*;
#(
   parameter int unsigned PRESC_W = 5,
   parameter int unsigned MIN_DIV = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [1:0]         cmd_smp_code,
   input  logic               cmd_diff,
   input  logic [PRESC_W-1:0] presc_in,
   output logic               config_error,
   output logic               adc_clk_en,
   output logic               sample_win,
   output logic               conv_win,
   output logic               conv_done
);
   localparam int unsigned DIV_W   = PRESC_W + 2;
   localparam int unsigned MAX_DIV = 2 * (1 << PRESC_W);

   if (PRESC_W < 1 || PRESC_W > 6) begin : g_bad_w
      $error("PRESC_W out of supported range");
   end
   if (MIN_DIV < 2 || MIN_DIV > MAX_DIV) begin : g_bad_min
      $error("MIN_DIV outside reachable divide factors");
   end

   phase_e phase;
   logic   tick;
   logic   idle;
   logic   fire;
   logic   cfg_err;

   // legality check of the requested divide factor
   if (MIN_DIV <= 2) begin : g_no_limit
      assign cfg_err = 1'b0;
   end else begin : g_limit
      logic [PRESC_W:0] req_p1;
      logic [DIV_W-1:0] req_div;
      assign req_p1  = {1'b0, presc_in} + (PRESC_W+1)'(1);
      assign req_div = {req_p1, 1'b0};
      assign cfg_err = (req_div < DIV_W'(MIN_DIV));
   end

   assign idle      = (phase == PH_IDLE);
   assign cmd_ready = idle && !cfg_err;
   assign fire      = cmd_valid && cmd_ready;

   adc_tick_gen #(.PRESC_W(PRESC_W)) tick_i (
      .clk      (clk),
      .rst      (rst),
      .load_en  (idle),
      .restart  (fire),
      .presc_in (presc_in),
      .tick     (tick)
   );

   adc_phase_seq seq_i (
      .clk      (clk),
      .rst      (rst),
      .fire     (fire),
      .smp_code (cmd_smp_code),
      .diff     (cmd_diff),
      .tick     (tick),
      .phase    (phase),
      .done     (conv_done)
   );

   assign config_error = cfg_err;
   assign adc_clk_en   = tick;
   assign sample_win   = (phase == PH_SAMPLE);
   assign conv_win     = (phase == PH_CONV);

endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk (
   input logic clk,
   input logic rst,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic config_error,
   input logic adc_clk_en,
   input logic sample_win,
   input logic conv_win,
   input logic conv_done
);
   AST_WIN_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(sample_win && conv_win)); // R3

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready) |=> (sample_win && !cmd_ready)); // R5

   AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      conv_done |-> (conv_win && adc_clk_en)); // R6

   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
      conv_done |=> (!conv_win && !sample_win)); // R7

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
      (sample_win || conv_win) |-> !cmd_ready); // R7

   AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (config_error && !sample_win && !conv_win) |=> !sample_win); // R9

endmodule

bind adc_conv_timer adc_conv_timer_chk chk_i (
   .clk          (clk),
   .rst          (rst),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .config_error (config_error),
   .adc_clk_en   (adc_clk_en),
   .sample_win   (sample_win),
   .conv_win     (conv_win),
   .conv_done    (conv_done)
);

// File: tb/adc_conv_timer_tb_top.sv
module adc_conv_timer_tb_top;
   localparam int unsigned PRESC_W = 5;
   localparam int unsigned MIN_DIV = 4;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               cmd_valid = 1'b0;
   logic               cmd_ready;
   logic [1:0]         cmd_smp_code = 2'b00;
   logic               cmd_diff = 1'b0;
   logic [PRESC_W-1:0] presc_in = 5'd2;
   logic               config_error;
   logic               adc_clk_en;
   logic               sample_win;
   logic               conv_win;
   logic               conv_done;

   int nchk  = 0;
   int nfail = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   adc_conv_timer #(.PRESC_W(PRESC_W), .MIN_DIV(MIN_DIV)) dut_i (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_smp_code(cmd_smp_code), .cmd_diff(cmd_diff), .presc_in(presc_in),
      .config_error(config_error), .adc_clk_en(adc_clk_en),
      .sample_win(sample_win), .conv_win(conv_win), .conv_done(conv_done)
   );

   function automatic int exp_div(input int n);
      return 2 * (n + 1);
   endfunction

   function automatic int exp_smp(input logic [1:0] code);
      case (code)
         2'b00:   return 2;
         2'b01:   return 8;
         2'b10:   return 64;
         default: return 128;
      endcase
   endfunction

   function automatic int exp_conv(input logic diff);
      return diff ? 13 : 14;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] code, input logic diff, input int n,
                          input bit mid_change);
      int smp = 0, cnv = 0, dn = 0, cyc = 0;
      bit done_last = 0, done_out = 0;
      presc_in = PRESC_W'(n);
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R7 ready idle", int'(cmd_ready), 1);
      cmd_smp_code = code;
      cmd_diff     = diff;
      cmd_valid    = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R7 ready after accept", int'(cmd_ready), 0);
      chk(sample_win == 1'b1, "R5 sample starts", int'(sample_win), 1);
      while (!cmd_ready && cyc < 20000) begin
         if (sample_win) smp++;
         if (conv_win) begin
            cnv++;
            done_last = conv_done;
         end
         if (conv_done) begin
            dn++;
            if (!conv_win) done_out = 1;
         end
         if (mid_change && cyc == 5) presc_in = PRESC_W'(n + 3);
         cyc++;
         @(negedge clk);
      end
      chk(smp == exp_smp(code) * exp_div(n), "R3 sample length", smp, exp_smp(code) * exp_div(n));
      chk(cnv == exp_conv(diff) * exp_div(n), "R4 convert length", cnv, exp_conv(diff) * exp_div(n));
      chk(cyc == (exp_smp(code) + exp_conv(diff)) * exp_div(n), "R5 busy total", cyc,
          (exp_smp(code) + exp_conv(diff)) * exp_div(n));
      chk(dn == 1 && !done_out, "R6 one done", dn, 1);
      chk(done_last, "R6 done in last cycle", int'(done_last), 1);
      chk(!sample_win && !conv_win, "R7 windows low at ready", int'(sample_win | conv_win), 0);
      if (mid_change) begin
         chk(cyc == (exp_smp(code) + exp_conv(diff)) * exp_div(n), "R8 presc change ignored", cyc,
             (exp_smp(code) + exp_conv(diff)) * exp_div(n));
      end
      presc_in = PRESC_W'(n);
   endtask

   task automatic check_period(input int n);
      int gap = 0;
      presc_in = PRESC_W'(n);
      repeat (140) @(negedge clk);
      while (!adc_clk_en) @(negedge clk);
      @(negedge clk);
      gap = 1;
      while (!adc_clk_en && gap < 200) begin
         @(negedge clk);
         gap++;
      end
      chk(gap == exp_div(n), "R2 tick period", gap, exp_div(n));
   endtask

   initial begin
      int seen;
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
      chk(!sample_win && !conv_win && !conv_done, "R1 outputs idle",
          int'({sample_win, conv_win, conv_done}), 0);

      check_period(1);
      check_period(0);
      check_period(6);

      // R9 illegal and boundary divide factors
      presc_in = 5'd0;
      @(negedge clk);
      chk(config_error == 1'b1, "R9 error flag", int'(config_error), 1);
      chk(cmd_ready == 1'b0, "R9 ready blocked", int'(cmd_ready), 0);
      cmd_valid = 1'b1;
      seen = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (sample_win || conv_win) seen++;
      end
      cmd_valid = 1'b0;
      chk(seen == 0, "R9 command ignored", seen, 0);
      presc_in = 5'd1;
      @(negedge clk);
      chk(config_error == 1'b0, "R9 boundary legal", int'(config_error), 0);

      // directed corners
      run_cmd(2'b00, 1'b1, 1, 0);
      run_cmd(2'b00, 1'b0, 1, 0);
      run_cmd(2'b11, 1'b0, 31, 0);
      run_cmd(2'b00, 1'b1, 31, 0);
      run_cmd(2'b10, 1'b1, 2, 1);
      run_cmd(2'b01, 1'b0, 4, 1);

      // random mix
      for (int k = 0; k < 16; k++) begin
         run_cmd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(1, 5)), 1'($urandom_range(0, 1)));
      end

      // R10 reset during a conversion
      presc_in = 5'd3;
      @(negedge clk);
      cmd_smp_code = 2'b11;
      cmd_valid    = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (50) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!sample_win && !conv_win && !conv_done, "R10 windows cleared",
          int'({sample_win, conv_win, conv_done}), 0);
      chk(cmd_ready == 1'b1, "R10 ready back", int'(cmd_ready), 1);
      run_cmd(2'b00, 1'b1, 2, 0);

      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule